// File: doc/BRIEF.md
# Serial Command/Data Register Slave

This block is a serial peripheral slave that gives an external master access to a small bank of byte-wide registers. Every access is one frame of exactly sixteen serial clocks. The first byte is a command: a direction flag and a register address. The second byte is either the value to store or the value returned. The block runs entirely on the serial clock and on chip-select edges, so it needs no system clock.

Incoming bits are taken on serial clock rising edges. Outgoing bits change on falling edges, which gives the master half a period to capture each one. A store is held back until the frame ends with exactly sixteen clocks and chip select is released. A fetch starts returning the addressed register right after the eighth clock. Releasing chip select at any point throws away the frame in progress. The serial output is driven only while chip select is low.

Top module: `spi_cd_slave`

## Requirements
- R1: A frame is sixteen serial clocks. Bits go most significant first: command byte, then data byte. Command bit 7 is the direction (1 = read, 0 = write) and command bits 6:0 are the register address.
- R2: Serial input is captured on serial clock rising edges. The serial output changes only on falling edges.
- R3: The output enable is high exactly while chip select is low. While chip select is high the serial output is high impedance.
- R4: The serial output is low during the command byte, and it stays low for the whole of a write frame.
- R5: A write frame of exactly sixteen clocks stores its data byte in the addressed register when chip select rises.
- R6: A write frame ended by chip select after fewer than sixteen clocks leaves every register unchanged.
- R7: A write frame that receives more than sixteen clocks before chip select rises is discarded.
- R8: In a read frame the addressed register appears on the output most significant bit first. Bit 7 is set up by the falling edge after the eighth rising edge. The input bits of the data byte are ignored, and the register is unchanged.
- R9: The active-low reset clears all 128 registers to zero.
- R10: Chip select high clears the bit counter and the shift state. A frame aborted at any bit count, read or write, does not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset; clears the register bank |
| cs_n | input | 1 | Active-low chip select; a rising edge commits a complete write |
| sclk | input | 1 | Serial clock; idles high between frames |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master, high impedance while deselected |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
The assertions check on every serial clock edge that the bit counter stays within its saturating range. They also check that the latched command is held once the command byte is complete, and that the output stays low unless a read command has been latched. On the write side they check that a pending write arises only from a full frame and is dropped on overrun. Whether a commit really waits for the chip-select edge, and whether aborted or overlong writes leave the bank untouched, can only be seen from the bench. It writes and reads every address, sweeps the abort point through all sixteen bit counts, and sends overlong frames. Reset clearing and the independence of one frame from the next are also shown by the bench, through readback.

// File: rtl/spi_cd_pkg.sv
package spi_cd_pkg;
  // Default geometry of the slave: 7-bit address, byte-wide registers.
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int CMD_W      = ADDR_W + 1;
  localparam int FRAME_BITS = CMD_W + DATA_W;
  // Counter must reach FRAME_BITS + 1 (overrun marker).
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int DEPTH      = 1 << ADDR_W;
endpackage

// File: rtl/spi_cd_shifter.sv
// Rising-edge receive path: bit counter, input shift register, command latch.
// Cleared asynchronously whenever chip select is high (clr_n low).
module spi_cd_shifter #(
  parameter int ADDR_W = spi_cd_pkg::ADDR_W,
  parameter int DATA_W = spi_cd_pkg::DATA_W,
  parameter int CNT_W  = spi_cd_pkg::CNT_W,
  parameter int SH_W   = (DATA_W > ADDR_W + 1) ? DATA_W : ADDR_W + 1
) (
  input  logic              sclk,
  input  logic              clr_n,
  input  logic              sdi,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [SH_W-1:0]   sh_nxt,
  output logic              cmd_rd,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int CMD_W = ADDR_W + 1;
  localparam int FRAME = CMD_W + DATA_W;
  localparam logic [CNT_W-1:0] CNT_CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CNT_CMD_DONE = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_SAT      = CNT_W'(FRAME + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cmd_ld;

  // Next-state
  always_comb begin
    cnt_d  = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
    sh_d   = {sh_q[SH_W-2:0], sdi};
    cmd_ld = (cnt_q == CNT_CMD_LAST);
  end

  // Registers
  always_ff @(posedge sclk or negedge clr_n) begin
    if (!clr_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      if (cmd_ld) begin
        rd_q   <= sh_d[CMD_W-1];
        addr_q <= sh_d[ADDR_W-1:0];
      end
    end
  end

  assign bit_cnt  = cnt_q;
  assign sh_nxt   = sh_d;
  assign cmd_rd   = rd_q;
  assign cmd_addr = addr_q;

  // R1: counter never runs past its overrun marker
  a_r1_cnt_bound: assert property (@(posedge sclk) disable iff (!clr_n)
    cnt_q <= CNT_SAT);

  // R8: the latched command is frozen once the command byte is complete
  a_r8_cmd_held: assert property (@(posedge sclk) disable iff (!clr_n)
    (cnt_q >= CNT_CMD_DONE) |=> ($stable(rd_q) && $stable(addr_q)));
endmodule

// File: rtl/spi_cd_wrcap.sv
// Pending-write holding register. Lives outside the chip-select clear so that
// the captured frame survives until the chip-select rising edge commits it.
module spi_cd_wrcap #(
  parameter int ADDR_W = spi_cd_pkg::ADDR_W,
  parameter int DATA_W = spi_cd_pkg::DATA_W,
  parameter int CNT_W  = spi_cd_pkg::CNT_W
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] data_in,
  output logic              wr_pend,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int FRAME = ADDR_W + 1 + DATA_W;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME + 1);

  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              cap, clk_en;

  // Next-state: arm on the sixteenth edge of a write; any other edge disarms.
  always_comb begin
    clk_en = !cs_n;
    cap    = (bit_cnt == CNT_LAST) && !cmd_rd;
    pend_d = cap;
    addr_d = cap ? cmd_addr : addr_q;
    data_d = cap ? data_in  : data_q;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (clk_en) begin
      pend_q <= pend_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_pend = pend_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;

  // R7: a seventeenth clock always leaves no write pending
  a_r7_overrun_drops: assert property (@(posedge sclk) disable iff (!rst_n)
    (!cs_n && bit_cnt == CNT_SAT) |-> !pend_q);

  // R5: a write becomes pending only at the end of a full frame
  a_r5_arm_on_full: assert property (@(posedge sclk) disable iff (!rst_n)
    (!cs_n && $rose(pend_q)) |-> (bit_cnt == CNT_FULL));
endmodule

// File: rtl/spi_cd_regbank.sv
// Register bank; the write port is clocked by the chip-select rising edge.
module spi_cd_regbank #(
  parameter int ADDR_W = spi_cd_pkg::ADDR_W,
  parameter int DATA_W = spi_cd_pkg::DATA_W
) (
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_pend,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              we;
    assign we = wr_pend && (wr_addr == ADDR_W'(g));
    always_ff @(posedge cs_n or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wr_data;
    end
    assign mem[g] = q;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_cd_txout.sv
// Falling-edge transmit path: loads the addressed register after the command
// byte of a read and shifts it out most significant bit first.
module spi_cd_txout #(
  parameter int ADDR_W = spi_cd_pkg::ADDR_W,
  parameter int DATA_W = spi_cd_pkg::DATA_W,
  parameter int CNT_W  = spi_cd_pkg::CNT_W
) (
  input  logic              sclk,
  input  logic              clr_n,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              cmd_rd,
  input  logic [DATA_W-1:0] rd_data,
  output logic              tx_bit
);
  localparam logic [CNT_W-1:0] CNT_CMD_DONE = CNT_W'(ADDR_W + 1);

  logic [DATA_W-1:0] tx_q, tx_d;
  logic              load;

  always_comb begin
    load = (bit_cnt == CNT_CMD_DONE) && cmd_rd;
    tx_d = load ? rd_data : {tx_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(negedge sclk or negedge clr_n) begin
    if (!clr_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

  assign tx_bit = tx_q[DATA_W-1];

  // R4: nothing but zeros leaves the slave unless a read has been decoded
  a_r4_quiet_unless_read: assert property (@(posedge sclk) disable iff (!clr_n)
    !cmd_rd |-> !tx_q[DATA_W-1]);
endmodule

// File: rtl/spi_cd_slave.sv
module spi_cd_slave #(
  parameter int ADDR_W = spi_cd_pkg::ADDR_W,
  parameter int DATA_W = spi_cd_pkg::DATA_W
) (
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int CMD_W = ADDR_W + 1;
  localparam int FRAME = CMD_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 2);
  localparam int SH_W  = (DATA_W > CMD_W) ? DATA_W : CMD_W;

  logic              clr_n;
  logic [CNT_W-1:0]  bit_cnt;
  logic [SH_W-1:0]   sh_nxt;
  logic              cmd_rd;
  logic [ADDR_W-1:0] cmd_addr;
  logic              wr_pend;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              tx_bit;

  // Frame state is held clear while deselected or in reset.
  assign clr_n = rst_n & ~cs_n;

  spi_cd_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_shift (
    .sclk     (sclk),
    .clr_n    (clr_n),
    .sdi      (sdi),
    .bit_cnt  (bit_cnt),
    .sh_nxt   (sh_nxt),
    .cmd_rd   (cmd_rd),
    .cmd_addr (cmd_addr)
  );

  spi_cd_wrcap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_wrcap (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .bit_cnt  (bit_cnt),
    .cmd_rd   (cmd_rd),
    .cmd_addr (cmd_addr),
    .data_in  (sh_nxt[DATA_W-1:0]),
    .wr_pend  (wr_pend),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  spi_cd_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wr_pend (wr_pend),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (cmd_addr),
    .rd_data (rd_data)
  );

  spi_cd_txout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
    .sclk    (sclk),
    .clr_n   (clr_n),
    .bit_cnt (bit_cnt),
    .cmd_rd  (cmd_rd),
    .rd_data (rd_data),
    .tx_bit  (tx_bit)
  );

  // R3: drive only while selected
  assign sdo_oe = ~cs_n;
  assign sdo    = sdo_oe ? tx_bit : 1'bz;
endmodule

// File: tb/spi_cd_slave_tb.sv
module spi_cd_slave_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, sclk, sdi;
  wire  sdo;
  logic sdo_oe;
  int   vec = 0, errs = 0, cyc = 0;

  spi_cd_slave u_dut (
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .sclk   (sclk),
    .sdi    (sdi),
    .sdo    (sdo),
    .sdo_oe (sdo_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 73 + 29) & 255);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vec++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One frame of nclk serial clocks; obs collects sdo just before each rise.
  task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat, input int nclk,
                      output logic [15:0] obs, output logic oe_in);
    logic [15:0] frame;
    frame = {cmd, dat};
    obs   = '0;
    oe_in = 1'b1;
    cs_n  = 1'b0;
    #5;
    sclk  = 1'b0;
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? frame[15-i] : 1'b0;
      #5;
      if (i < 16) obs[15-i] = sdo;
      if (!sdo_oe) oe_in = 1'b0;
      sclk = 1'b1;
      #5;
      sclk = 1'b0;
    end
    #5;
    cs_n = 1'b1;
    #5;
    sclk = 1'b1;
    #10;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    logic [15:0] o;
    logic        e;
    xfer({1'b1, 7'(a)}, 8'hA5, 16, o, e);
    v = o[7:0];
  endtask

  logic [15:0] obs;
  logic        oe;
  logic [7:0]  v;

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0;
    #23;
    chk("R3 idle enable", {15'd0, sdo_oe}, 16'd0);
    rst_n = 1'b1;
    #12;

    // R9: every register reads zero after reset
    for (int a = 0; a < 128; a++) begin
      xfer({1'b1, 7'(a)}, 8'h00, 16, obs, oe);
      chk("R9 reset value", {8'd0, obs[7:0]}, 16'd0);
      if (a == 0) begin
        chk("R4 command phase low", {8'd0, obs[15:8]}, 16'd0);
        chk("R3 enable while selected", {15'd0, oe}, 16'd1);
        chk("R3 enable after release", {15'd0, sdo_oe}, 16'd0);
      end
    end

    // R5 / R4: write every address, output stays low throughout
    for (int a = 0; a < 128; a++) begin
      xfer({1'b0, 7'(a)}, pat(a), 16, obs, oe);
      chk("R4 write frame quiet", obs, 16'd0);
    end
    // R5 R8 R2 R1: read back every address
    for (int a = 0; a < 128; a++) begin
      rd(a, v);
      chk("R5 R8 R2 R1 readback", {8'd0, v}, {8'd0, pat(a)});
    end

    // R6: aborted writes at each bit count leave the target unchanged
    for (int n = 0; n < 16; n++) begin
      xfer({1'b0, 7'(100 + n)}, ~pat(100 + n), n, obs, oe);
      rd(100 + n, v);
      chk("R6 aborted write", {8'd0, v}, {8'd0, pat(100 + n)});
    end

    // R7: overlong write frames are discarded
    for (int n = 17; n < 21; n++) begin
      xfer({1'b0, 7'(n)}, ~pat(n), n, obs, oe);
      rd(n, v);
      chk("R7 overrun write", {8'd0, v}, {8'd0, pat(n)});
    end

    // R10: reads aborted at each count, then a clean frame
    for (int n = 0; n < 16; n++) begin
      xfer({1'b1, 7'd7}, 8'hFF, n, obs, oe);
      rd(9, v);
      chk("R10 frame after abort", {8'd0, v}, {8'd0, pat(9)});
    end

    // R8: read with arbitrary data byte leaves register intact
    xfer({1'b1, 7'd10}, 8'h5A, 16, obs, oe);
    chk("R8 read value", {8'd0, obs[7:0]}, {8'd0, pat(10)});
    rd(10, v);
    chk("R8 read non-destructive", {8'd0, v}, {8'd0, pat(10)});

    // R5: overwrite then read
    xfer({1'b0, 7'd127}, 8'h81, 16, obs, oe);
    rd(127, v);
    chk("R5 overwrite", {8'd0, v}, 16'h0081);

    // R9: reset again mid-run
    rst_n = 1'b0;
    #20;
    rst_n = 1'b1;
    #12;
    for (int a = 0; a < 4; a++) begin
      rd(a * 40, v);
      chk("R9 second reset", {8'd0, v}, 16'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
      $finish;
    end
  end
endmodule